// File: doc/BRIEF.md
# Serial Receive Descrambler with Sync Status

This block removes the transmit scrambling from the serial bit stream of a 100 Mb/s twisted-pair receiver. It sits after the line receiver and before the 4B5B symbol decoder, and it handles one bit per valid cycle. It finds the transmitter's keystream by itself from the idle stream. It then keeps running freely and reports through a status flag whether it is synchronized.

The keystream is an 11-stage linear feedback sequence with k[n] = k[n-11] XOR k[n-9], which is the polynomial x^11 + x^9 + 1. Each output bit is the received bit XOR the keystream bit. While the block is not synchronized, it assumes that the plaintext is idle (all ones). It therefore loads its register with the inverted received bits, and it declares lock after 30 descrambled ones in a row. Once locked, the register runs on its own feedback. Lock is dropped when no run of 30 ones is seen within `TIMEOUT` valid bits.

Descrambling is done only in 100 Mb/s twisted-pair mode with bypass clear. The fiber mode, the 10 Mb/s modes and bypass all pass the received bit through unchanged. In every mode the output appears exactly one cycle after the input.

Top module: `rx_descrambler`

## Requirements
- R1: After reset, `lossOfSync` is 1 and `outValid` is 0.
- R2: `outValid` equals `inValid` from the previous cycle, in every mode.
- R3: With `linkMode` = 0 and `bypassEn` = 0, the keystream follows k[n] = k[n-11] XOR k[n-9], and `outBit` = received bit XOR k[n], one cycle after the input.
- R4: While unsynchronized, the block assumes the plaintext is ones. After 30 consecutive descrambled ones it locks, and `lossOfSync` clears on the clock edge that takes the 30th one. It cannot lock after fewer than 30 valid bits.
- R5: Once locked, every valid bit is descrambled to its plaintext. This holds for arbitrary data and across cycles with `inValid` low, which leave the state unchanged.
- R6: A locked block becomes unsynchronized, and `lossOfSync` rises, when `TIMEOUT` valid bits pass without a run of at least 30 descrambled ones.
- R7: Once set, `lossOfSync` stays 1 until lock is regained, whatever data arrives.
- R8: With `bypassEn` = 1, `outBit` is the received bit from the previous cycle, unchanged.
- R9: With `linkMode` = 1 (100 Mb/s fiber), `outBit` is the received bit from the previous cycle, unchanged.
- R10: With `linkMode` = 2 (10 Mb/s) or 3, `outBit` is the received bit from the previous cycle, unchanged.
- R11: Any change of `linkMode` or `bypassEn` drops lock and forces re-acquisition. `lossOfSync` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| inBit | input | 1 | Received serial bit |
| inValid | input | 1 | Qualifies `inBit` |
| linkMode | input | 2 | 0: 100 Mb/s twisted pair, 1: 100 Mb/s fiber, 2/3: 10 Mb/s |
| bypassEn | input | 1 | Passes data through without descrambling |
| outBit | output | 1 | Descrambled or passed-through bit |
| outValid | output | 1 | Qualifies `outBit` |
| lossOfSync | output | 1 | 1 while the descrambler is not synchronized |

## Verification
The bench drives three kinds of pattern. The first is scrambled idle, which checks that the block acquires lock at the right point: lock must not come early and must come within the allowed window. The second is scrambled random data with random valid gaps. It separates a correct free-running keystream from one that slips or takes the wrong taps. The same data, kept from ever holding 30 ones in a row for long enough, separates the timeout and the sticky flag from a flag that simply follows the last bit. The third is raw random bits in bypass, fiber and 10 Mb/s modes, which must reappear unchanged. It shows that descrambling is gated off, and that each configuration change forces a fresh acquisition.

// File: rtl/rx_descrambler_pkg.sv
package rx_descrambler_pkg;
  localparam int LFSR_LEN = 11;
  localparam int TAP_FAR  = 10;  // k[n-11]
  localparam int TAP_NEAR = 8;   // k[n-9]

  localparam logic [1:0] MODE_TX100 = 2'd0;

  typedef struct packed {
    logic step;      // advance the keystream register this cycle
    logic track;     // 1: feed back predicted key, 0: load inverted received bit
    logic descr;     // 1: output descrambled bit, 0: pass through
  } descCtl_t;
endpackage

// File: rtl/rx_descrambler_dp.sv
module rx_descrambler_dp
  import rx_descrambler_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inBit,
  input  logic     inValid,
  input  descCtl_t ctl,
  output logic     descrBit,
  output logic     outBit,
  output logic     outValid
);
  logic [LFSR_LEN-1:0] keyReg;
  logic keyBit;

  assign keyBit   = keyReg[TAP_FAR] ^ keyReg[TAP_NEAR];
  assign descrBit = inBit ^ keyBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg   <= '0;
      outBit   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) outBit <= ctl.descr ? descrBit : inBit;
      if (ctl.step) keyReg <= {keyReg[LFSR_LEN-2:0], ctl.track ? keyBit : ~inBit};
    end
  end
endmodule

// File: rtl/rx_descrambler_ctl.sv
module rx_descrambler_ctl
  import rx_descrambler_pkg::*;
#(
  parameter int RUN_LEN = 30,
  parameter int TIMEOUT = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] linkMode,
  input  logic       bypassEn,
  input  logic       descrBit,
  output descCtl_t   ctl,
  output logic       locked
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [RW-1:0] runCnt, runNext;
  logic [TW-1:0] toCnt;
  logic [2:0]    cfgPrev;
  logic          active, cfgChanged, runHit;

  assign active     = (linkMode == MODE_TX100) && !bypassEn;
  assign cfgChanged = {linkMode, bypassEn} != cfgPrev;
  assign runNext    = !descrBit ? '0 :
                      (runCnt == RW'(RUN_LEN)) ? runCnt : runCnt + 1'b1;
  assign runHit     = runNext == RW'(RUN_LEN);

  always_comb begin
    ctl.step  = inValid && active && !cfgChanged;
    ctl.track = locked;
    ctl.descr = active;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt  <= '0;
      toCnt   <= '0;
      locked  <= 1'b0;
      cfgPrev <= {MODE_TX100, 1'b0};
    end else begin
      cfgPrev <= {linkMode, bypassEn};
      if (!active || cfgChanged) begin
        runCnt <= '0;
        toCnt  <= '0;
        locked <= 1'b0;
      end else if (inValid) begin
        runCnt <= runNext;
        if (runHit) begin
          locked <= 1'b1;
          toCnt  <= '0;
        end else if (locked && toCnt == TW'(TIMEOUT - 1)) begin
          locked <= 1'b0;
          toCnt  <= '0;
          runCnt <= '0;
        end else if (locked) begin
          toCnt <= toCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_descrambler.sv
module rx_descrambler
  import rx_descrambler_pkg::*;
#(
  parameter int RUN_LEN = 30,
  parameter int TIMEOUT = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inBit,
  input  logic       inValid,
  input  logic [1:0] linkMode,
  input  logic       bypassEn,
  output logic       outBit,
  output logic       outValid,
  output logic       lossOfSync
);
  descCtl_t ctl;
  logic descrBit, locked;

  rx_descrambler_ctl #(.RUN_LEN(RUN_LEN), .TIMEOUT(TIMEOUT)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .linkMode(linkMode),
    .bypassEn(bypassEn), .descrBit(descrBit), .ctl(ctl), .locked(locked)
  );

  rx_descrambler_dp u_dp (
    .clk(clk), .rstN(rstN), .inBit(inBit), .inValid(inValid), .ctl(ctl),
    .descrBit(descrBit), .outBit(outBit), .outValid(outValid)
  );

  // Status is set whenever lock is absent and clears only when lock returns.
  assign lossOfSync = !locked;
endmodule

// File: rtl/rx_descrambler_chk.sv
module rx_descrambler_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inBit,
  input logic       inValid,
  input logic [1:0] linkMode,
  input logic       bypassEn,
  input logic       outBit,
  input logic       outValid,
  input logic       lossOfSync
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (linkMode != 2'd0 || bypassEn)) |=> (outBit == $past(inBit))); // R8
  AST_LOS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (lossOfSync && !inValid) |=> lossOfSync); // R7
  AST_LOCK_ONLY_TX: assert property (@(posedge clk) disable iff (!rstN)
    (linkMode != 2'd0 || bypassEn) |=> lossOfSync); // R10
  AST_CFG_RELOCK: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(linkMode) || !$stable(bypassEn)) |=> lossOfSync); // R11
endmodule

bind rx_descrambler rx_descrambler_chk u_chk (
  .clk(clk), .rstN(rstN), .inBit(inBit), .inValid(inValid), .linkMode(linkMode),
  .bypassEn(bypassEn), .outBit(outBit), .outValid(outValid), .lossOfSync(lossOfSync)
);

// File: tb/rx_descrambler_tb.sv
module rx_descrambler_tb;
  localparam int TMO = 200;

  logic clk = 1'b0, rstN = 1'b0;
  logic inBit = 1'b0, inValid = 1'b0, bypassEn = 1'b0;
  logic [1:0] linkMode = 2'd0;
  logic outBit, outValid, lossOfSync;

  int total = 0, bad = 0;
  logic [10:0] txKey = 11'h5A3;
  int sinceZero = 0;

  always #2 clk = ~clk;

  rx_descrambler #(.TIMEOUT(TMO)) u_dut (
    .clk(clk), .rstN(rstN), .inBit(inBit), .inValid(inValid), .linkMode(linkMode),
    .bypassEn(bypassEn), .outBit(outBit), .outValid(outValid), .lossOfSync(lossOfSync)
  );

  function automatic logic nextKey(input logic [10:0] k);
    return k[10] ^ k[8];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Send one scrambled plaintext bit (optionally preceded by an idle gap cycle).
  task automatic sendTx(input logic plain, input bit chkData, input bit gap);
    logic k;
    if (gap) begin
      @(negedge clk); inValid = 1'b0; inBit = $urandom;
      @(posedge clk); #1; check("R2 gap", outValid, 1'b0);
    end
    k = nextKey(txKey);
    txKey = {txKey[9:0], k};
    @(negedge clk); inValid = 1'b1; inBit = plain ^ k;
    @(posedge clk); #1;
    check("R2", outValid, 1'b1);
    if (chkData) check("R3/R5 data", outBit, plain);
  endtask

  task automatic sendRaw(input string req);
    logic b;
    b = $urandom;
    @(negedge clk); inValid = 1'b1; inBit = b;
    @(posedge clk); #1;
    check(req, outBit, b);
  endtask

  function automatic logic dataBit();
    logic b;
    b = $urandom;
    if (sinceZero >= 15) b = 1'b0;
    sinceZero = b ? sinceZero + 1 : 0;
    return b;
  endfunction

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 los", lossOfSync, 1'b1);
    check("R1 valid", outValid, 1'b0);
    @(negedge clk); rstN = 1'b1;

    // Acquire on idle
    for (int i = 0; i < 20; i++) sendTx(1'b1, 1'b0, 1'b0);
    check("R4 no early lock", lossOfSync, 1'b1);
    for (int i = 0; i < 40; i++) sendTx(1'b1, 1'b0, 1'b0);
    check("R4 locked", lossOfSync, 1'b0);

    // Random data with gaps, below timeout
    for (int i = 0; i < 150; i++) sendTx(dataBit(), 1'b1, ($urandom % 4) == 0);
    check("R6 still locked", lossOfSync, 1'b0);
    for (int i = 0; i < 100; i++) sendTx(dataBit(), 1'b0, 1'b0);
    check("R6 lock lost", lossOfSync, 1'b1);
    for (int i = 0; i < 60; i++) begin
      sendTx(dataBit(), 1'b0, 1'b0);
      check("R7 sticky", lossOfSync, 1'b1);
    end

    // Relock on idle
    for (int i = 0; i < 60; i++) sendTx(1'b1, 1'b0, 1'b0);
    check("R7 clears on relock", lossOfSync, 1'b0);
    for (int i = 0; i < 40; i++) sendTx(dataBit(), 1'b1, 1'b0);

    // Bypass
    @(negedge clk); bypassEn = 1'b1; inValid = 1'b0;
    @(posedge clk); #1; check("R11 bypass drops lock", lossOfSync, 1'b1);
    for (int i = 0; i < 40; i++) sendRaw("R8 bypass");
    @(negedge clk); bypassEn = 1'b0; inValid = 1'b0;
    @(posedge clk); #1;
    for (int i = 0; i < 60; i++) sendTx(1'b1, 1'b0, 1'b0);
    check("R11 relock after bypass", lossOfSync, 1'b0);

    // Fiber and 10 Mb/s modes
    @(negedge clk); linkMode = 2'd1; inValid = 1'b0;
    @(posedge clk); #1; check("R11 mode change drops lock", lossOfSync, 1'b1);
    for (int i = 0; i < 40; i++) sendRaw("R9 fiber");
    @(negedge clk); linkMode = 2'd2;
    for (int i = 0; i < 40; i++) sendRaw("R10 10M");
    @(negedge clk); linkMode = 2'd3;
    for (int i = 0; i < 20; i++) sendRaw("R10 mode3");
    check("R10 no lock", lossOfSync, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule